// File: doc/BRIEF.md
# Indexed Effective Address Sequencer

This block runs the bus cycles that turn an instruction's base-address bytes and an 8-bit index into an effective memory address. It then performs the operand access at that address. A start pulse tells it where the operand bytes sit in the instruction stream (`pc_in`), which addressing form to use, which index register to apply, and whether the access is a read, a write or a read-modify-write. The block then drives the memory address bus and the write strobe one cycle at a time. It advances its program counter past the base bytes it fetches, and it signals completion with a single-cycle pulse.

Two addressing forms are supported. The absolute form fetches a low and a high base byte. The index is added to the low byte while the high byte is being fetched. When that add overflows, one extra read is issued at the uncorrected address while the high byte is incremented. The zero-page form fetches one base byte and spends one discarded read on page zero while the add takes place. The resulting address always stays on page zero. A cycle whose address may still be wrong is always a read. Write and read-modify-write accesses in the absolute form always take the correction cycle, so their timing does not depend on the data.

Opcode decode, arithmetic and the next opcode fetch are left to the surrounding core. For a read-modify-write, the modified byte is supplied on `store_val` by that core.

Top module: `idx_ea_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0 and `pc_out` is 0.
- R2: Absolute form (`mode`=0), read class (`op_class`=0), with the low byte plus the index below 256, issues exactly three bus cycles, all reads: `pc_in`, `pc_in`+1, and then {high, low+index} as the operand access.
- R3: Absolute form, read class, with the low byte plus the index of 256 or more, issues four read cycles: `pc_in`, `pc_in`+1, {high, (low+index) mod 256} as a dummy read, and then {high+1 mod 256, (low+index) mod 256}.
- R4: Zero-page form (`mode`=1) issues three cycles: a read at `pc_in`, a dummy read at {00, base}, and the access at {00, (base+index) mod 256}. For example, base F7 with index 10 accesses 0007.
- R5: `idx_sel`=0 selects `x_idx` and `idx_sel`=1 selects `y_idx`, in both forms.
- R6: Write class (`op_class`=1) asserts `mem_we` in exactly one cycle, the last one, with `mem_wdata`=`store_val`. In the absolute form it always takes the correction cycle, so the high byte is incremented only on a carry.
- R7: Read-modify-write class (`op_class`=2) reads at the effective address and writes `store_val` to the same address in the next cycle. In the absolute form it always takes the correction cycle.
- R8: `pc_out` loads `pc_in` at start and increments once per base byte fetched: twice in the absolute form, once in the zero-page form. It does not change in dummy or operand cycles.
- R9: `done` pulses for exactly one cycle, the cycle after the last bus cycle. At that point `rd_data` holds the byte read in the operand access of a read or read-modify-write.
- R10: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mode | input | 1 | 0 absolute form, 1 zero-page form |
| idx_sel | input | 1 | 0 use x_idx, 1 use y_idx |
| op_class | input | 2 | 0 read, 1 write, 2 read-modify-write |
| x_idx | input | 8 | Index register X value |
| y_idx | input | 8 | Index register Y value |
| pc_in | input | 16 | Address of the first base byte |
| store_val | input | 8 | Byte to write for write or read-modify-write |
| mem_addr | output | 16 | Memory address bus |
| mem_rdata | input | 8 | Memory read data, valid in the cycle addressed |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe; the cycle is a read when 0 |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Operand byte captured in the access cycle |
| pc_out | output | 16 | Program counter after the base-byte fetches |

## Verification
Directed cases separate the absolute form with and without a low-byte carry, including a carry out of high byte FF. They also cover the zero-page wrap from F7 plus 10 and Y selected in both forms. These cases tell the no-penalty path apart from the penalty path, and show the high-byte increment apart from zero-page forcing. Writes without a carry show that the correction cycle is taken regardless of the data. Read-modify-write shows that the write lands on the same corrected address. A start pulse with different settings in the middle of a sequence must leave the bus trace unchanged. Seeded random operations, mixing all forms, classes and index values, are compared cycle by cycle against a bus trace built by a bench function.

// File: rtl/idx_ea_pkg.sv
// Shared types for the indexed effective address sequencer.
// Assumes: encodings below are the block's port-level encodings.
package idx_ea_pkg;

    typedef enum logic {
        EA_ABS = 1'b0,
        EA_ZP  = 1'b1
    } ea_mode_e;

    typedef enum logic [1:0] {
        OPC_RD  = 2'd0,
        OPC_WR  = 2'd1,
        OPC_RMW = 2'd2,
        OPC_RSV = 2'd3
    } op_cls_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_LO   = 3'd1,
        SQ_HI   = 3'd2,
        SQ_ZPD  = 3'd3,
        SQ_FIX  = 3'd4,
        SQ_ACC  = 3'd5,
        SQ_WB   = 3'd6
    } seq_st_e;

endpackage

// File: rtl/idx_ea_pc.sv
// Program counter for the base-byte fetches.
// Loads the start address when a sequence is accepted and steps by one
// for each base byte fetched. Assumes load and step are never both high.
module idx_ea_pc #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] pc_q
);

    // Counter register: load on accept, step on fetch, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (load) begin
            pc_q <= load_val;
        end else if (step) begin
            pc_q <= pc_q + AW'(1);
        end
    end

endmodule

// File: rtl/idx_ea_fsm.sv
// Bus-cycle sequencer control.
// Latches mode and class at accept, walks the fetch/dummy/access states
// and raises done in the cycle after the last bus cycle.
// Assumes carry_nx is valid while in SQ_HI (low byte plus index).
module idx_ea_fsm
    import idx_ea_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     mode,
    input  logic [1:0] op_class,
    input  logic     carry_nx,
    output seq_st_e  st_q,
    output ea_mode_e mode_q,
    output op_cls_e  cls_q,
    output logic     accept,
    output logic     done
);

    seq_st_e st_nx;
    logic    wr_kind;

    assign accept  = start && (st_q == SQ_IDLE);
    assign wr_kind = (cls_q == OPC_WR) || (cls_q == OPC_RMW);

    // Next-state selection for the cycle sequence.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SQ_IDLE: if (start) st_nx = SQ_LO;
            SQ_LO:   st_nx = (mode_q == EA_ABS) ? SQ_HI : SQ_ZPD;
            SQ_HI:   st_nx = (carry_nx || wr_kind) ? SQ_FIX : SQ_ACC;
            SQ_ZPD:  st_nx = SQ_ACC;
            SQ_FIX:  st_nx = SQ_ACC;
            SQ_ACC:  st_nx = (cls_q == OPC_RMW) ? SQ_WB : SQ_IDLE;
            SQ_WB:   st_nx = SQ_IDLE;
            default: st_nx = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_nx;
    end

    // Capture mode and class when a sequence is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= EA_ABS;
            cls_q  <= OPC_RD;
        end else if (accept) begin
            mode_q <= ea_mode_e'(mode);
            cls_q  <= op_cls_e'(op_class);
        end
    end

    // Completion pulse one cycle after the final bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= ((st_q == SQ_ACC) && (cls_q != OPC_RMW)) || (st_q == SQ_WB);
    end

endmodule

// File: rtl/idx_ea_dp.sv
// Address datapath: base byte registers, index adder, high-byte fixup,
// address/strobe selection and read-data capture.
// Assumes mem_rdata is valid during the cycle whose address is driven.
module idx_ea_dp
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_st_e       st,
    input  op_cls_e       cls,
    input  logic          accept,
    input  logic          idx_sel,
    input  logic [DW-1:0] x_idx,
    input  logic [DW-1:0] y_idx,
    input  logic [DW-1:0] store_val,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [DW-1:0] rd_data,
    output logic          carry_nx,
    output logic          carry_q
);

    localparam int HW = AW - DW;

    logic [DW-1:0] lo_q;
    logic [HW-1:0] hi_q;
    logic [DW-1:0] idx_q;
    logic [DW-1:0] sum_q;
    logic [DW-1:0] sum_nx;
    logic [DW-1:0] wv_q;

    // Index adder on the low base byte; carry feeds the sequencer.
    assign {carry_nx, sum_nx} = {1'b0, lo_q} + {1'b0, idx_q};

    // Latch the selected index and store byte when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            wv_q  <= '0;
        end else if (accept) begin
            idx_q <= idx_sel ? y_idx : x_idx;
            wv_q  <= store_val;
        end
    end

    // Base bytes, sum and high-byte correction per state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            unique case (st)
                SQ_LO: lo_q <= mem_rdata;
                SQ_HI: begin
                    hi_q    <= mem_rdata[HW-1:0];
                    sum_q   <= sum_nx;
                    carry_q <= carry_nx;
                end
                SQ_ZPD: begin
                    hi_q    <= '0;
                    sum_q   <= sum_nx;
                    carry_q <= 1'b0;
                end
                SQ_FIX: hi_q <= hi_q + HW'(carry_q);
                default: ;
            endcase
        end
    end

    // Address selection for each bus cycle.
    always_comb begin
        unique case (st)
            SQ_ZPD:                 mem_addr = {{HW{1'b0}}, lo_q};
            SQ_FIX, SQ_ACC, SQ_WB:  mem_addr = {hi_q, sum_q};
            default:                mem_addr = pc;
        endcase
    end

    assign mem_we    = ((st == SQ_ACC) && (cls == OPC_WR)) || (st == SQ_WB);
    assign mem_wdata = wv_q;

    // Operand capture in the access cycle of read-type classes.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rd_data <= '0;
        else if ((st == SQ_ACC) && (cls != OPC_WR)) rd_data <= mem_rdata;
    end

endmodule

// File: rtl/idx_ea_seq.sv
// Indexed effective address sequencer, top level.
// Ties the controller, datapath and program counter together.
// Assumes a memory that answers a read in the cycle it is addressed.
module idx_ea_seq
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic          idx_sel,
    input  logic [1:0]    op_class,
    input  logic [DW-1:0] x_idx,
    input  logic [DW-1:0] y_idx,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] store_val,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] pc_out
);

    seq_st_e  st_q;
    ea_mode_e mode_q;
    op_cls_e  cls_q;
    logic     accept;
    logic     carry_nx;
    logic     carry_q;
    logic     pc_step;

    assign busy    = (st_q != SQ_IDLE);
    assign pc_step = (st_q == SQ_LO) || (st_q == SQ_HI);

    idx_ea_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .op_class (op_class),
        .carry_nx (carry_nx),
        .st_q     (st_q),
        .mode_q   (mode_q),
        .cls_q    (cls_q),
        .accept   (accept),
        .done     (done)
    );

    idx_ea_pc #(.AW(AW)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (pc_in),
        .step     (pc_step),
        .pc_q     (pc_out)
    );

    idx_ea_dp #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st_q),
        .cls       (cls_q),
        .accept    (accept),
        .idx_sel   (idx_sel),
        .x_idx     (x_idx),
        .y_idx     (y_idx),
        .store_val (store_val),
        .pc        (pc_out),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .rd_data   (rd_data),
        .carry_nx  (carry_nx),
        .carry_q   (carry_q)
    );

endmodule

// File: rtl/idx_ea_chk.sv
// Protocol checker for idx_ea_seq, attached by bind below.
module idx_ea_chk
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input seq_st_e       st,
    input ea_mode_e      mode_q,
    input logic          carry_q,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          done,
    input logic [AW-1:0] pc_out
);

    // R6: fetch and dummy cycles are always reads.
    assert_dummy_is_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_LO || st == SQ_HI || st == SQ_ZPD || st == SQ_FIX) |-> !mem_we);

    // R4: zero-page accesses stay on page zero.
    assert_zp_page_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == EA_ZP && (st == SQ_ZPD || st == SQ_ACC || st == SQ_WB))
        |-> (mem_addr[AW-1:DW] == '0));

    // R3: after the dummy cycle the low byte holds and the high byte adds the carry.
    assert_fix_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_FIX) |=> (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]))
        && (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW]) + (AW-DW)'($past(carry_q))));

    // R7: the write of a read-modify-write hits the address just read.
    assert_rmw_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WB) |-> (mem_we && mem_addr == $past(mem_addr)));

    // R8: the counter holds through dummy and operand cycles.
    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_ZPD || st == SQ_FIX || st == SQ_ACC) |=> $stable(pc_out));

    // R9: done lasts a single cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind idx_ea_seq idx_ea_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st_q),
    .mode_q   (mode_q),
    .carry_q  (carry_q),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .done     (done),
    .pc_out   (pc_out)
);

// File: tb/idx_ea_seq_tb_top.sv
`timescale 1ns/1ps
module idx_ea_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic        idx_sel = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [7:0]  x_idx = '0;
    logic [7:0]  y_idx = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  store_val = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        busy;
    logic        done;
    logic [7:0]  rd_data;
    logic [15:0] pc_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // program bytes placed at prog_pc and prog_pc+1
    logic [15:0] prog_pc = '0;
    logic [7:0]  prog_b0 = '0;
    logic [7:0]  prog_b1 = '0;

    // observed and expected bus traces
    logic [15:0] obs_a [8];
    logic        obs_w [8];
    logic [7:0]  obs_d [8];
    int          obs_n;
    logic [15:0] exp_a [8];
    logic        exp_w [8];
    int          exp_n;

    always #2 clk = ~clk;

    idx_ea_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx_sel(idx_sel),
        .op_class(op_class), .x_idx(x_idx), .y_idx(y_idx), .pc_in(pc_in),
        .store_val(store_val), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done),
        .rd_data(rd_data), .pc_out(pc_out)
    );

    function automatic logic [7:0] bg(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        if (a == prog_pc)              return prog_b0;
        if (a == prog_pc + 16'd1)      return prog_b1;
        return bg(a);
    endfunction

    assign mem_rdata = mem_model(mem_addr);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Build the expected trace from the requirements.
    task automatic build_exp(input bit zp, input logic [1:0] cls, input logic [7:0] idx,
                             output logic [15:0] ea);
        logic [8:0]  s;
        logic [7:0]  hi;
        exp_n = 0;
        s = {1'b0, prog_b0} + {1'b0, idx};
        exp_a[exp_n] = prog_pc; exp_w[exp_n] = 1'b0; exp_n++;
        if (zp) begin
            exp_a[exp_n] = {8'h00, prog_b0}; exp_w[exp_n] = 1'b0; exp_n++;
            ea = {8'h00, s[7:0]};
        end else begin
            hi = prog_b1;
            exp_a[exp_n] = prog_pc + 16'd1; exp_w[exp_n] = 1'b0; exp_n++;
            if (s[8] || cls != 2'd0) begin
                exp_a[exp_n] = {hi, s[7:0]}; exp_w[exp_n] = 1'b0; exp_n++;
            end
            ea = {hi + {7'd0, s[8]}, s[7:0]};
        end
        exp_a[exp_n] = ea; exp_w[exp_n] = (cls == 2'd1); exp_n++;
        if (cls == 2'd2) begin
            exp_a[exp_n] = ea; exp_w[exp_n] = 1'b1; exp_n++;
        end
    endtask

    // Run one sequence and compare its bus trace.
    task automatic run_op(input bit zp, input bit sel, input logic [1:0] cls,
                          input logic [7:0] xv, input logic [7:0] yv,
                          input logic [15:0] pcv, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] wv,
                          input bit glitch, input string tag);
        logic [15:0] ea;
        logic [7:0]  idx;
        int k;
        bit ok;
        idx = sel ? yv : xv;
        @(negedge clk);
        prog_pc = pcv; prog_b0 = b0; prog_b1 = b1;
        mode = zp; idx_sel = sel; op_class = cls; x_idx = xv; y_idx = yv;
        pc_in = pcv; store_val = wv; start = 1'b1;
        build_exp(zp, cls, idx, ea);
        obs_n = 0;
        k = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (glitch && k == 1) begin
                // R10: disturbing start mid-sequence
                start = 1'b1; mode = ~zp; idx_sel = ~sel; x_idx = xv + 8'h33;
                y_idx = yv + 8'h77; pc_in = pcv + 16'h1234; store_val = ~wv;
            end
            if (done) break;
            if (busy && obs_n < 8) begin
                obs_a[obs_n] = mem_addr; obs_w[obs_n] = mem_we; obs_d[obs_n] = mem_wdata;
                obs_n++;
            end
            k++;
            if (k > 12) break;
        end
        start = 1'b0;
        chk(obs_n == exp_n, tag, "cycle count", 32'(obs_n), 32'(exp_n));
        for (int i = 0; i < 8; i++) begin
            if (i < exp_n && i < obs_n) begin
                ok = (obs_a[i] == exp_a[i]) && (obs_w[i] == exp_w[i]);
                chk(ok, tag, $sformatf("cycle %0d addr/we", i),
                    {15'd0, obs_w[i], obs_a[i]}, {15'd0, exp_w[i], exp_a[i]});
                if (exp_w[i])
                    chk(obs_d[i] == wv, tag, "write data", 32'(obs_d[i]), 32'(wv));
            end
        end
        chk(pc_out == pcv + (zp ? 16'd1 : 16'd2), "R8", "pc_out at done",
            32'(pc_out), 32'(pcv + (zp ? 16'd1 : 16'd2)));
        if (cls != 2'd1)
            chk(rd_data == bg(ea) || (ea == pcv || ea == pcv + 16'd1), "R9",
                "rd_data", 32'(rd_data), 32'(bg(ea)));
        @(negedge clk);
        chk(done == 1'b0, "R9", "done single pulse", 32'(done), 32'd0);
    endtask

    function automatic string tag_of(input bit zp, input logic [1:0] cls,
                                     input logic [7:0] lo, input logic [7:0] idx);
        logic [8:0] s;
        s = {1'b0, lo} + {1'b0, idx};
        if (zp)          return "R4";
        if (cls == 2'd1) return "R6";
        if (cls == 2'd2) return "R7";
        if (s[8])        return "R3";
        return "R2";
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && done == 1'b0 && mem_we == 1'b0, "R1", "flags in reset",
            {29'd0, busy, done, mem_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_out == 16'h0000, "R1", "pc_out after reset", 32'(pc_out), 32'd0);
        chk(busy == 1'b0 && done == 1'b0 && mem_we == 1'b0, "R1", "idle after reset",
            {29'd0, busy, done, mem_we}, 32'd0);

        // R2: absolute read, no carry
        run_op(1'b0, 1'b0, 2'd0, 8'h05, 8'h00, 16'h0101, 8'h20, 8'h34, 8'h00, 1'b0, "R2");
        // R3: absolute read, carry
        run_op(1'b0, 1'b0, 2'd0, 8'h30, 8'h00, 16'h0200, 8'hF0, 8'h12, 8'h00, 1'b0, "R3");
        // R3: carry out of high byte FF wraps to page 00
        run_op(1'b0, 1'b0, 2'd0, 8'h01, 8'h00, 16'h0300, 8'hFF, 8'hFF, 8'h00, 1'b0, "R3");
        // R4: zero-page wrap F7 + 10 -> 0007
        run_op(1'b1, 1'b0, 2'd0, 8'h10, 8'h00, 16'h0400, 8'hF7, 8'h99, 8'h00, 1'b0, "R4");
        // R5: Y selected, X holds a different value, both forms
        run_op(1'b0, 1'b1, 2'd0, 8'hEE, 8'h02, 16'h0500, 8'h40, 8'h66, 8'h00, 1'b0, "R5");
        run_op(1'b1, 1'b1, 2'd0, 8'hEE, 8'h03, 16'h0600, 8'h80, 8'h00, 8'h00, 1'b0, "R5");
        // R6: absolute write without carry still takes the fix cycle
        run_op(1'b0, 1'b0, 2'd1, 8'h01, 8'h00, 16'h0700, 8'h10, 8'h22, 8'h5C, 1'b0, "R6");
        // R6: absolute write with carry
        run_op(1'b0, 1'b1, 2'd1, 8'h00, 8'h90, 16'h0800, 8'h90, 8'h22, 8'hC3, 1'b0, "R6");
        // R7: read-modify-write, absolute and zero-page
        run_op(1'b0, 1'b0, 2'd2, 8'h04, 8'h00, 16'h0900, 8'h08, 8'h45, 8'hA1, 1'b0, "R7");
        run_op(1'b1, 1'b0, 2'd2, 8'hFF, 8'h00, 16'h0A00, 8'h02, 8'h00, 8'h3E, 1'b0, "R7");
        // R10: start pulsed mid-sequence is ignored
        run_op(1'b0, 1'b0, 2'd0, 8'h10, 8'h00, 16'h0B00, 8'hF8, 8'h10, 8'h00, 1'b1, "R10");
        run_op(1'b1, 1'b0, 2'd1, 8'h10, 8'h00, 16'h0C00, 8'h20, 8'h10, 8'h77, 1'b1, "R10");

        // constrained random mix
        for (int n = 0; n < 80; n++) begin
            bit          zp;
            bit          sel;
            logic [1:0]  cls;
            logic [7:0]  xv, yv, b0, b1, wv;
            logic [15:0] pcv;
            zp  = 1'($urandom_range(0, 1));
            sel = 1'($urandom_range(0, 1));
            cls = 2'($urandom_range(0, 2));
            xv  = 8'($urandom);
            yv  = 8'($urandom);
            b0  = 8'($urandom);
            b1  = 8'($urandom);
            wv  = 8'($urandom);
            pcv = 16'($urandom_range(16'h1000, 16'hFFF0));
            run_op(zp, sel, cls, xv, yv, pcv, b0, b1, wv, 1'b0,
                   tag_of(zp, cls, b0, sel ? yv : xv));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule